// File: doc/BRIEF.md
# Received-Block Buffer with Read Request

This block stores decoded radio data blocks between the synchronizer/error-correction stage and a serial host port. Each stored item holds 16 data bits and 13 status flag bits. The upstream stage writes one item per `wr_en_i` pulse. The host selects the port with `sel_i` and consumes the head record one bit at a time with `shift_i`. The block shows the 32-bit record that the external shifter serializes. It adds two fields to that record: a flag that says another record follows, and a coarse count of how many records are held.

An active-low request line, `req_no`, tells the host that data is waiting. The line goes low once occupancy reaches a threshold chosen by the host. It is forced high for a fixed number of clock cycles after every read. It is held high after a synchronization reset until the upstream stage reports lock. All timing is counted in cycles of `clk_i`.

Top module: `rx_block_buffer`

## Requirements
- R1: The buffer holds at most DEPTH (24) records. After 24 records have been read out of a full buffer, the next record read is all zero.
- R2: `req_no` is low when occupancy is at or above the threshold selected by `thr_sel_i`: 0 selects 1 record, 1 selects 4, 2 selects 8 and 3 selects 12. One record less keeps it high.
- R3: When `sel_i` falls, `req_no` is high for exactly HOLD_CYC cycles. After that it goes low if at least one record remains, even if the count is below the threshold.
- R4: While the buffer is empty, `req_no` is high.
- R5: A one-cycle `sync_rst_i` pulse empties the buffer. `req_no` then stays high, even when records are written, until `lock_i` is seen high.
- R6: Record layout: bit 31 is the more-data flag, bits 30:29 are the count field, bits 28:16 are the stored flags and bits 15:0 are the data. The more-data flag is 1 when two or more records are held at the start of the read, and 0 when the record is the last.
- R7: The count field is 0 for 1-7 held records, 1 for 8-15, 2 for 16-23 and 3 for 24. The count includes the record being read.
- R8: With no record held, `rec_o` is all zero and a read of it consumes nothing. Any number of such zero records can be read in a row.
- R9: From bit 0 until the last bit of a record, `rec_o` stays constant. Records follow one another in a single selection, and each 32 shifts moves to the next record.
- R10: A read dropped before 31 shifts leaves the record in place, and the next read starts with it again. A read dropped after 31 shifts counts the record as consumed.
- R11: A write into a full buffer discards the oldest record, and the count stays at 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write one record |
| wr_data_i | input | 16 | Data word of the record |
| wr_flag_i | input | 13 | Status flags of the record |
| sel_i | input | 1 | Host port select (chip enable) |
| shift_i | input | 1 | One record bit consumed this cycle |
| rec_o | output | 32 | Record for the serializer |
| thr_sel_i | input | 2 | Request threshold select |
| sync_rst_i | input | 1 | Synchronization reset: flush and block request |
| lock_i | input | 1 | Synchronization acquired |
| req_no | output | 1 | Read request, active low |

## Verification
The assertions assume that `shift_i` is only meaningful while `sel_i` is high, and that writes do not coincide with a `sync_rst_i` pulse. They also assume that `lock_i` and `sync_rst_i` are never raised in the same cycle. The stimulus drives every input on the falling clock edge. It raises `shift_i` only inside a selection and keeps writes and reads in separate phases. It pulses synchronization reset and lock one cycle each, several cycles apart. Each read runs to the 32-bit boundary or stops at a chosen bit count. Before it checks the threshold, the bench waits for the post-read window to end.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;
  localparam int DATA_W = 16;
  localparam int FLAG_W = 13;
  localparam int REC_W  = 32;
  localparam int ITEM_W = DATA_W + FLAG_W;
  localparam int BIN    = 8;

  typedef struct packed {
    logic              more;
    logic [1:0]        rcnt;
    logic [FLAG_W-1:0] flags;
    logic [DATA_W-1:0] data;
  } rec_t;

  function automatic int unsigned thr_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/bb_store.sv
module bb_store #(
  parameter int DEPTH = 24,
  parameter int W     = 29,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          full;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (cnt_q == CW'(DEPTH));
  assign ovf_o  = wr_i && full && !pop_i;
  assign head_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_i) wp_q <= nxt(wp_q);
      // overflow drops the oldest entry
      if (pop_i || ovf_o) rp_q <= nxt(rp_q);
      case ({wr_i && !ovf_o, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R1
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  // R11
  ovf_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !flush_i) |=> cnt_q == CW'(DEPTH));
  // R8
  no_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/bb_port.sv
module bb_port
  import blkbuf_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int BW   = $clog2(REC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              sel_i,
  input  logic              shift_i,
  input  logic [ITEM_W-1:0] head_i,
  input  logic [CW-1:0]     cnt_i,
  input  logic              ovf_i,
  output logic [REC_W-1:0]  rec_o,
  output logic              pop_o
);
  logic [BW-1:0] bit_q;
  rec_t          view, hold_q;
  logic          hold_vld_q;
  logic          step;

  always_comb begin
    view = '0;
    if (cnt_i != '0) begin
      view.more = (cnt_i >= CW'(2));
      if (cnt_i >= CW'(DEPTH))      view.rcnt = 2'd3;
      else if (cnt_i >= CW'(2*BIN)) view.rcnt = 2'd2;
      else if (cnt_i >= CW'(BIN))   view.rcnt = 2'd1;
      else                          view.rcnt = 2'd0;
      {view.flags, view.data} = head_i;
    end
  end

  assign step  = sel_i && shift_i;
  // record is consumed once only its last bit is left
  assign pop_o = step && (bit_q == BW'(REC_W - 2)) && hold_vld_q;
  assign rec_o = (bit_q == '0) ? view : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q      <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (flush_i) begin
      bit_q      <= '0;
      hold_vld_q <= 1'b0;
    end else if (!sel_i) begin
      bit_q <= '0;
      if (ovf_i) hold_vld_q <= 1'b0;
    end else begin
      if (step) begin
        bit_q <= (bit_q == BW'(REC_W - 1)) ? '0 : bit_q + 1'b1;
        if (bit_q == '0) begin
          hold_q     <= view;
          hold_vld_q <= (cnt_i != '0);
        end
      end
      if (ovf_i) hold_vld_q <= 1'b0;
    end
  end

  // R9
  rec_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !flush_i && bit_q != BW'(REC_W - 1)) |=> $stable(rec_o));
endmodule

// File: rtl/bb_req.sv
module bb_req
  import blkbuf_pkg::*;
#(
  parameter int DEPTH    = 24,
  parameter int HOLD_CYC = 64,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int WW      = $clog2(HOLD_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [1:0]    thr_sel_i,
  input  logic          sync_rst_i,
  input  logic          lock_i,
  output logic          req_no
);
  logic          sel_q, blk_q, resid_q;
  logic [WW-1:0] win_q;
  logic          sel_fall, win_end, at_thr;

  assign sel_fall = sel_q && !sel_i;
  assign win_end  = (win_q == WW'(1));
  assign at_thr   = (cnt_i >= CW'(thr_of(thr_sel_i)));
  assign req_no   = !(!blk_q && (win_q == '0) && (cnt_i != '0) && (resid_q || at_thr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      win_q   <= '0;
      blk_q   <= 1'b0;
      resid_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      if (sel_fall)          win_q <= WW'(HOLD_CYC);
      else if (win_q != '0)  win_q <= win_q - 1'b1;
      if (sync_rst_i)        blk_q <= 1'b1;
      else if (lock_i)       blk_q <= 1'b0;
      // leftovers after a read re-raise the request regardless of threshold
      if (sync_rst_i || cnt_i == '0) resid_q <= 1'b0;
      else if (win_end && !sel_fall) resid_q <= 1'b1;
    end
  end

  // R3
  win_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_fall |=> req_no);
endmodule

// File: rtl/rx_block_buffer.sv
module rx_block_buffer
  import blkbuf_pkg::*;
#(
  parameter int DEPTH    = 24,
  parameter int HOLD_CYC = 64,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [FLAG_W-1:0] wr_flag_i,
  input  logic              sel_i,
  input  logic              shift_i,
  output logic [REC_W-1:0]  rec_o,
  input  logic [1:0]        thr_sel_i,
  input  logic              sync_rst_i,
  input  logic              lock_i,
  output logic              req_no
);
  logic [ITEM_W-1:0] head;
  logic [CW-1:0]     cnt;
  logic              pop, ovf;

  bb_store #(.DEPTH(DEPTH), .W(ITEM_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (sync_rst_i),
    .wr_i    (wr_en_i),
    .wdata_i ({wr_flag_i, wr_data_i}),
    .pop_i   (pop),
    .head_o  (head),
    .cnt_o   (cnt),
    .ovf_o   (ovf)
  );

  bb_port #(.DEPTH(DEPTH)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (sync_rst_i),
    .sel_i   (sel_i),
    .shift_i (shift_i),
    .head_i  (head),
    .cnt_i   (cnt),
    .ovf_i   (ovf),
    .rec_o   (rec_o),
    .pop_o   (pop)
  );

  bb_req #(.DEPTH(DEPTH), .HOLD_CYC(HOLD_CYC)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel_i),
    .cnt_i      (cnt),
    .thr_sel_i  (thr_sel_i),
    .sync_rst_i (sync_rst_i),
    .lock_i     (lock_i),
    .req_no     (req_no)
  );

  // R4
  empty_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == '0 |-> req_no);
  // R5
  sync_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rst_i |=> req_no);
  // R8
  empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !sel_i) |-> rec_o == '0);
endmodule

// File: tb/rx_block_buffer_test.sv
`timescale 1ns/1ps
module rx_block_buffer_test;
  localparam int HOLD = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [12:0] wr_flag = '0;
  logic        sel = 1'b0, shift = 1'b0;
  logic [31:0] rec_o;
  logic [1:0]  thr_sel = 2'd0;
  logic        sync_rst = 1'b0, lock = 1'b0;
  logic        req_no;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [28:0] model[$];

  always #2.5 clk = ~clk;

  rx_block_buffer #(.DEPTH(24), .HOLD_CYC(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_flag_i(wr_flag), .sel_i(sel), .shift_i(shift), .rec_o(rec_o),
    .thr_sel_i(thr_sel), .sync_rst_i(sync_rst), .lock_i(lock), .req_no(req_no)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h want %h", tag, act, exp);
    end
  endtask

  task automatic req_is(input logic e, input string tag);
    #1 check(tag, {31'b0, req_no}, {31'b0, e});
  endtask

  // R6 R7: expected record from the scoreboard queue
  function automatic logic [31:0] exp_rec();
    int n;
    logic [1:0] b;
    n = model.size();
    if (n == 0) return 32'h0;
    b = (n >= 24) ? 2'd3 : (n >= 16) ? 2'd2 : (n >= 8) ? 2'd1 : 2'd0;
    return {(n >= 2), b, model[0]};
  endfunction

  task automatic push(input logic [15:0] d, input logic [12:0] f);
    @(negedge clk); wr_en = 1'b1; wr_data = d; wr_flag = f;
    @(negedge clk); wr_en = 1'b0;
    if (model.size() == 24) void'(model.pop_front());
    model.push_back({f, d});
  endtask

  task automatic rd_rec(input int n, input string tag);
    logic [31:0] e;
    @(negedge clk); sel = 1'b1; #1;
    e = exp_rec();
    check(tag, rec_o, e);
    for (int i = 0; i < n; i++) begin
      shift = 1'b1;
      @(negedge clk); #1;
      if (i == 30) begin
        if (e != 32'h0) void'(model.pop_front());
        check(tag, rec_o, e);
      end
    end
    shift = 1'b0;
  endtask

  task automatic drop(input bit remain, input string tag);
    sel = 1'b0;
    repeat (HOLD) @(negedge clk);
    #1 check(tag, {31'b0, req_no}, 32'd1);
    @(negedge clk); #1;
    check(tag, {31'b0, req_no}, remain ? 32'd0 : 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req_is(1'b1, "R4 reset");
    check("R8 reset", rec_o, 32'h0);

    push(16'h1111, 13'h0a1);
    req_is(1'b0, "R2 thr 1");
    rd_rec(32, "R6 single");
    drop(1'b0, "R4 empty after read");
    rd_rec(32, "R8 zero a");
    rd_rec(32, "R8 zero b");
    drop(1'b0, "R8 window");

    @(negedge clk); thr_sel = 2'd1;
    push(16'h2222, 13'h001);
    push(16'h3333, 13'h002);
    push(16'h4444, 13'h003);
    req_is(1'b1, "R2 below 4");
    push(16'h5555, 13'h004);
    req_is(1'b0, "R2 at 4");
    rd_rec(10, "R10 cut");
    drop(1'b1, "R3 window");
    rd_rec(31, "R10 restart");
    drop(1'b1, "R3 window");
    rd_rec(32, "R10 next");
    rd_rec(32, "R9 back to back");
    drop(1'b1, "R3 leftover below thr");
    rd_rec(32, "R6 last");
    rd_rec(32, "R8 zero after data");
    drop(1'b0, "R4 drained");

    @(negedge clk); thr_sel = 2'd0;
    for (int i = 0; i < 25; i++) push(16'h0100 + 16'(i), 13'(i));
    req_is(1'b0, "R11 full");
    for (int i = 0; i < 24; i++) rd_rec(32, (i == 0) ? "R11 oldest dropped" : "R7 count bins");
    rd_rec(32, "R1 capacity");
    drop(1'b0, "R4 after drain");

    push(16'h6666, 13'h010);
    push(16'h7777, 13'h011);
    @(negedge clk); sync_rst = 1'b1;
    @(negedge clk); sync_rst = 1'b0;
    model.delete();
    req_is(1'b1, "R5 after sync");
    rd_rec(32, "R5 flushed");
    drop(1'b0, "R5 window");
    push(16'h8888, 13'h012);
    push(16'h9999, 13'h013);
    req_is(1'b1, "R5 hold");
    @(negedge clk); lock = 1'b1;
    @(negedge clk); lock = 1'b0;
    req_is(1'b0, "R5 locked");
    rd_rec(32, "R5 data a");
    rd_rec(32, "R5 data b");
    drop(1'b0, "R4 empty");

    @(negedge clk); thr_sel = 2'd2;
    for (int i = 0; i < 7; i++) push(16'h0a00 + 16'(i), 13'h020);
    req_is(1'b1, "R2 below 8");
    push(16'h0a07, 13'h020);
    req_is(1'b0, "R2 at 8");
    for (int i = 0; i < 8; i++) rd_rec(32, "R9 drain 8");
    drop(1'b0, "R4 empty");

    @(negedge clk); thr_sel = 2'd3;
    for (int i = 0; i < 11; i++) push(16'h0b00 + 16'(i), 13'h030);
    req_is(1'b1, "R2 below 12");
    push(16'h0b0b, 13'h030);
    req_is(1'b0, "R2 at 12");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule